// File: doc/BRIEF.md
# Command-Driven SPI Controller Register Front End

This block is the software-facing side of a command-driven SPI controller. Software talks to it with single 32-bit word reads and writes on a plain valid/address/data register port. Behind that port the block keeps three queues. A 16-bit instruction queue feeds the command executor. An 8-bit outgoing-byte queue feeds the serializer. An 8-bit incoming-byte queue is filled by the deserializer. Each queue connects to the engine through a valid/ready handshake.

Software first reads how much room or data a queue has, then pushes instructions and bytes or drains received bytes. A separate peek address returns the oldest received byte without removing it. Four interrupt causes are collected in a pending register: instruction queue running low, outgoing queue running low, incoming queue running high, and a sync marker having been executed. An enable mask selects which causes drive the single interrupt line. The block also holds a soft-reset control for the engine, a fixed version word, and the identifier carried by the most recent sync marker.

Top module: `spie_regif`

## Requirements
- R1: A read of offset 0x00 returns the version word: major number 1 in bits 23:16, minor in 15:8, patch in 7:0, and zero in bits 31:24. Writes to it have no effect.
- R2: Bit 0 at offset 0x40 drives `engine_rst`, reads back, and is 1 after reset. While it is 1, `cmd_valid` and `tx_valid` stay low, even when queue entries are waiting.
- R3: A write to 0x E0 (offset 0xE0) pushes bits 15:0 into the instruction queue. Entries leave in push order on `cmd_valid && cmd_ready`. A push to a full queue is dropped. Offset 0xD0 reads depth minus occupancy.
- R4: A write to offset 0xE4 pushes bits 7:0 into the outgoing queue, and the upper bits are ignored. Entries leave in order on `tx_valid && tx_ready`. Offset 0xD4 reads depth minus occupancy.
- R5: The engine places bytes in the incoming queue with `rx_valid && rx_ready`. `rx_ready` is low exactly when the queue is full. Offset 0xD8 reads the occupancy.
- R6: A read of offset 0xE8 returns the oldest incoming byte in bits 7:0 and removes it. A read of 0xEC returns the same byte and keeps it. Either read of an empty queue returns 0 and changes nothing.
- R7: In the pending register (offset 0x84), bit 0 is set in every cycle in which instruction occupancy is at or below `CMD_LOW_MARK`. Bit 1 is set likewise for outgoing occupancy at or below `TX_LOW_MARK`. Bit 2 is set while incoming occupancy is at or above `RX_HIGH_MARK`. Bit 3 is set by a `sync_valid` pulse. Writing 1 to a bit clears it, writing 0 leaves it. When a set and a clear meet in the same cycle, the set wins.
- R8: Offset 0x80 holds a 4-bit read/write enable mask that resets to 0. Offset 0x88 reads pending AND enable. `irq` is high exactly when that value is non-zero.
- R9: Offset 0xC0 returns the `sync_id` captured with the most recent `sync_valid` pulse, and 0 after reset.
- R10: Every read yields `rsp_valid` with `rsp_rdata` in the following cycle. Reads of unmapped offsets return 0. Writes to unmapped or read-only offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt line |
| engine_rst | output | 1 | Soft reset to the engine |
| cmd_valid | output | 1 | Instruction available |
| cmd_ready | input | 1 | Executor takes the instruction |
| cmd_data | output | 16 | Oldest instruction |
| tx_valid | output | 1 | Outgoing byte available |
| tx_ready | input | 1 | Serializer takes the byte |
| tx_data | output | 8 | Oldest outgoing byte |
| rx_valid | input | 1 | Deserializer offers a byte |
| rx_ready | output | 1 | Incoming queue has room |
| rx_data | input | 8 | Incoming byte |
| sync_valid | input | 1 | Executor finished a sync marker |
| sync_id | input | 8 | Identifier of that marker |

## Verification
The hardest cases to reach are the ones where a level-driven pending bit must be seen to clear. The bench has to move a queue out of its watermark region through the ports before it writes the clear. That means parking several instructions with `cmd_ready` held low, or filling the incoming queue past its high mark and then draining it by pops. Only then does it read the pending register. The full and empty edges are reached the same way: pushes beyond depth and pops beyond occupancy are directed on purpose. Random rounds then vary the burst length, the data and the handshake timing against an order model kept in the bench.

// File: rtl/spie_pkg.sv
package spie_pkg;

  // Byte offsets; software decodes these, so they are fixed.
  localparam logic [7:0] OFS_VERSION  = 8'h00;
  localparam logic [7:0] OFS_SOFTRST  = 8'h40;
  localparam logic [7:0] OFS_IRQ_EN   = 8'h80;
  localparam logic [7:0] OFS_IRQ_PEND = 8'h84;
  localparam logic [7:0] OFS_IRQ_SRC  = 8'h88;
  localparam logic [7:0] OFS_SYNC_ID  = 8'hC0;
  localparam logic [7:0] OFS_CMD_ROOM = 8'hD0;
  localparam logic [7:0] OFS_TX_ROOM  = 8'hD4;
  localparam logic [7:0] OFS_RX_LEVEL = 8'hD8;
  localparam logic [7:0] OFS_CMD_PUSH = 8'hE0;
  localparam logic [7:0] OFS_TX_PUSH  = 8'hE4;
  localparam logic [7:0] OFS_RX_POP   = 8'hE8;
  localparam logic [7:0] OFS_RX_PEEK  = 8'hEC;

  // Interrupt cause bit positions.
  localparam int IRQ_CMD_LOW  = 0;
  localparam int IRQ_TX_LOW   = 1;
  localparam int IRQ_RX_HIGH  = 2;
  localparam int IRQ_SYNC     = 3;
  localparam int IRQ_N        = 4;

  localparam logic [7:0] VERSION_MAJOR = 8'd1;

  function automatic logic [31:0] make_version(input logic [7:0] minor_v,
                                               input logic [7:0] patch_v);
    return {8'h00, VERSION_MAJOR, minor_v, patch_v};
  endfunction

  function automatic logic [31:0] room_word(input int depth, input int level);
    return 32'(depth - level);
  endfunction

endpackage

// File: rtl/spie_fifo.sv
module spie_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    level,
  output logic             full,
  output logic             empty
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == CAP);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/spie_irq.sv
module spie_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] pend,
  output logic [N-1:0] en,
  output logic [N-1:0] src,
  output logic         irq
);

  function automatic logic [N-1:0] next_pend(input logic [N-1:0] cur,
                                             input logic [N-1:0] setv,
                                             input logic [N-1:0] clrv);
    return (cur & ~clrv) | setv;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= next_pend(pend, set_vec, clr_vec);
      if (en_wr) en <= en_wdata;
    end
  end

  assign src = pend & en;
  assign irq = |src;

endmodule

// File: rtl/spie_regif.sv
module spie_regif
  import spie_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          CMD_DEPTH    = 8,
  parameter int          TX_DEPTH     = 8,
  parameter int          RX_DEPTH     = 8,
  parameter int          CMD_LOW_MARK = 2,
  parameter int          TX_LOW_MARK  = 2,
  parameter int          RX_HIGH_MARK = 6,
  parameter logic [7:0]  VER_MINOR    = 8'h00,
  parameter logic [7:0]  VER_PATCH    = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              irq,
  output logic              engine_rst,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [15:0]       cmd_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              sync_valid,
  input  logic [7:0]        sync_id
);

  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  // Decoded bus events, named for the checker.
  logic wr_evt, rd_evt;
  logic wr_softrst, wr_en, wr_pend, wr_cmd, wr_tx;
  logic rd_pop;

  logic [7:0] ofs;
  assign ofs    = 8'(req_addr);
  assign wr_evt = req_valid && req_write;
  assign rd_evt = req_valid && !req_write;

  assign wr_softrst = wr_evt && (ofs == OFS_SOFTRST);
  assign wr_en      = wr_evt && (ofs == OFS_IRQ_EN);
  assign wr_pend    = wr_evt && (ofs == OFS_IRQ_PEND);
  assign wr_cmd     = wr_evt && (ofs == OFS_CMD_PUSH);
  assign wr_tx      = wr_evt && (ofs == OFS_TX_PUSH);
  assign rd_pop     = rd_evt && (ofs == OFS_RX_POP);

  // Soft reset and sync identifier.
  logic       softrst_q;
  logic [7:0] sync_id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      softrst_q <= 1'b1;
      sync_id_q <= '0;
    end else begin
      if (wr_softrst) softrst_q <= req_wdata[0];
      if (sync_valid) sync_id_q <= sync_id;
    end
  end

  assign engine_rst = softrst_q;

  // Queues.
  logic [15:0]    cmd_head;
  logic [CCW-1:0] cmd_level;
  logic           cmd_full, cmd_empty, cmd_pop;
  logic [7:0]     tx_head;
  logic [TCW-1:0] tx_level;
  logic           tx_full, tx_empty, tx_pop;
  logic [7:0]     rx_head;
  logic [RCW-1:0] rx_level;
  logic           rx_full, rx_empty, rx_push;

  assign cmd_valid = !cmd_empty && !softrst_q;
  assign cmd_data  = cmd_head;
  assign cmd_pop   = cmd_valid && cmd_ready;

  assign tx_valid  = !tx_empty && !softrst_q;
  assign tx_data   = tx_head;
  assign tx_pop    = tx_valid && tx_ready;

  assign rx_ready  = !rx_full;
  assign rx_push   = rx_valid && rx_ready;

  spie_fifo #(.WIDTH(16), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_cmd), .push_data(req_wdata[15:0]),
    .pop(cmd_pop), .head(cmd_head), .level(cmd_level),
    .full(cmd_full), .empty(cmd_empty)
  );

  spie_fifo #(.WIDTH(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(wr_tx), .push_data(req_wdata[7:0]),
    .pop(tx_pop), .head(tx_head), .level(tx_level),
    .full(tx_full), .empty(tx_empty)
  );

  spie_fifo #(.WIDTH(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_data),
    .pop(rd_pop), .head(rx_head), .level(rx_level),
    .full(rx_full), .empty(rx_empty)
  );

  // Interrupt causes.
  logic [IRQ_N-1:0] irq_set, irq_clr, pend_q, en_q, src_q;

  always_comb begin
    irq_set              = '0;
    irq_set[IRQ_CMD_LOW] = (int'(cmd_level) <= CMD_LOW_MARK);
    irq_set[IRQ_TX_LOW]  = (int'(tx_level)  <= TX_LOW_MARK);
    irq_set[IRQ_RX_HIGH] = (int'(rx_level)  >= RX_HIGH_MARK);
    irq_set[IRQ_SYNC]    = sync_valid;
  end

  assign irq_clr = wr_pend ? req_wdata[IRQ_N-1:0] : '0;

  spie_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_vec(irq_set), .clr_vec(irq_clr),
    .en_wr(wr_en), .en_wdata(req_wdata[IRQ_N-1:0]),
    .pend(pend_q), .en(en_q), .src(src_q), .irq(irq)
  );

  // Read path, registered.
  logic [31:0] rd_word;

  always_comb begin
    case (ofs)
      OFS_VERSION:  rd_word = make_version(VER_MINOR, VER_PATCH);
      OFS_SOFTRST:  rd_word = {31'd0, softrst_q};
      OFS_IRQ_EN:   rd_word = 32'(en_q);
      OFS_IRQ_PEND: rd_word = 32'(pend_q);
      OFS_IRQ_SRC:  rd_word = 32'(src_q);
      OFS_SYNC_ID:  rd_word = {24'd0, sync_id_q};
      OFS_CMD_ROOM: rd_word = room_word(CMD_DEPTH, int'(cmd_level));
      OFS_TX_ROOM:  rd_word = room_word(TX_DEPTH, int'(tx_level));
      OFS_RX_LEVEL: rd_word = 32'(rx_level);
      OFS_RX_POP,
      OFS_RX_PEEK:  rd_word = {24'd0, rx_head};
      default:      rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_evt;
      if (rd_evt) rsp_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/spie_regif_chk.sv
module spie_regif_chk #(
  parameter int CMD_DEPTH    = 8,
  parameter int RX_DEPTH     = 8,
  parameter int CMD_LOW_MARK = 2,
  parameter int CCW          = 4,
  parameter int RCW          = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_evt,
  input logic           wr_pend,
  input logic [31:0]    req_wdata,
  input logic           rsp_valid,
  input logic           engine_rst,
  input logic           cmd_valid,
  input logic           tx_valid,
  input logic           rx_ready,
  input logic           sync_valid,
  input logic [CCW-1:0] cmd_level,
  input logic [RCW-1:0] rx_level,
  input logic [3:0]     pend_q,
  input logic [3:0]     en_q,
  input logic           irq
);

  p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_evt |=> rsp_valid);

  p_no_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> !rsp_valid);

  p_hold_engine_r2: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |-> (!cmd_valid && !tx_valid));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cmd_level) <= CMD_DEPTH);

  p_rx_backpress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) == RX_DEPTH) |-> !rx_ready);

  p_cmd_low_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cmd_level) <= CMD_LOW_MARK) |=> pend_q[0]);

  p_sync_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> pend_q[3]);

  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pend && req_wdata[3] && !sync_valid) |=> !pend_q[3]);

  p_mask_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'd0) |-> !irq);

endmodule

bind spie_regif spie_regif_chk #(
  .CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH), .CMD_LOW_MARK(CMD_LOW_MARK),
  .CCW(CCW), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .wr_pend(wr_pend),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .engine_rst(engine_rst),
  .cmd_valid(cmd_valid), .tx_valid(tx_valid), .rx_ready(rx_ready),
  .sync_valid(sync_valid), .cmd_level(cmd_level), .rx_level(rx_level),
  .pend_q(pend_q), .en_q(en_q), .irq(irq)
);

// File: tb/sim_spie_regif.sv
module sim_spie_regif;

  localparam int         DEP   = 8;
  localparam logic [7:0] MINOR = 8'h00;
  localparam logic [7:0] PATCH = 8'h61;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq, engine_rst;
  logic        cmd_valid, cmd_ready = 1'b0;
  logic [15:0] cmd_data;
  logic        tx_valid, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [7:0]  rx_data = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spie_regif #(.CMD_DEPTH(DEP), .TX_DEPTH(DEP), .RX_DEPTH(DEP),
               .VER_MINOR(MINOR), .VER_PATCH(PATCH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .irq(irq), .engine_rst(engine_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sync_valid(sync_valid), .sync_id(sync_id));

  function automatic logic [31:0] exp_version();
    return (32'd1 << 16) | (32'(MINOR) << 8) | 32'(PATCH);
  endfunction

  function automatic logic [31:0] exp_room(int used);
    int u = (used > DEP) ? DEP : used;
    return 32'(DEP - u);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      n_bad++;
      $display("FAIL R10 actual=%h expected=%h (rsp_valid)", 32'(rsp_valid), 32'd1);
    end
    d = rsp_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] mask,
                        input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    chk((v & mask) == (exp & mask), req, v & mask, exp & mask);
  endtask

  task automatic take_cmd(input logic [15:0] exp, input string req);
    chk(cmd_valid && cmd_data == exp, req, {15'd0, cmd_valid, cmd_data},
        {16'd1, exp});
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
  endtask

  task automatic give_rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] q[$];
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    rd_chk(8'h00, '1, exp_version(), "R1");
    rd_chk(8'h40, '1, 32'd1, "R2");
    rd_chk(8'h80, '1, 32'd0, "R8");
    rd_chk(8'hC0, '1, 32'd0, "R9");
    rd_chk(8'hD0, '1, exp_room(0), "R3");
    rd_chk(8'hD4, '1, exp_room(0), "R4");
    rd_chk(8'hD8, '1, 32'd0, "R5");
    chk(!irq, "R8", 32'(irq), 32'd0);

    // R2: held engine sees nothing, release shows the entry
    wr(8'hE0, 32'h0000_1234);
    chk(!cmd_valid, "R2", 32'(cmd_valid), 32'd0);
    wr(8'h40, 32'd0);
    chk(engine_rst == 1'b0, "R2", 32'(engine_rst), 32'd0);
    take_cmd(16'h1234, "R2");

    // R3: overfill then drain in order
    for (int i = 0; i < 10; i++) wr(8'hE0, 32'hFFFF_0000 | 32'(i * 16'h111 + 1));
    rd_chk(8'hD0, '1, exp_room(10), "R3");
    for (int i = 0; i < DEP; i++) take_cmd(16'(i * 16'h111 + 1), "R3");
    chk(!cmd_valid, "R3", 32'(cmd_valid), 32'd0);

    // R4: outgoing bytes, upper bits ignored
    wr(8'hE4, 32'hABCD_EE55);
    wr(8'hE4, 32'h0000_01A6);
    wr(8'hE4, 32'h7777_7707);
    rd_chk(8'hD4, '1, exp_room(3), "R4");
    begin
      logic [7:0] exp_tx[3] = '{8'h55, 8'hA6, 8'h07};
      for (int i = 0; i < 3; i++) begin
        chk(tx_valid && tx_data == exp_tx[i], "R4", {23'd0, tx_valid, tx_data},
            {23'd0, 1'b1, exp_tx[i]});
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
      end
    end

    // R5/R6: incoming bytes, peek vs pop, empty read
    give_rx(8'hA1); give_rx(8'hB2); give_rx(8'hC3);
    rd_chk(8'hD8, '1, 32'd3, "R5");
    rd_chk(8'hEC, '1, 32'hA1, "R6");
    rd_chk(8'hEC, '1, 32'hA1, "R6");
    rd_chk(8'hD8, '1, 32'd3, "R6");
    rd_chk(8'hE8, '1, 32'hA1, "R6");
    rd_chk(8'hE8, '1, 32'hB2, "R6");
    rd_chk(8'hD8, '1, 32'd1, "R6");
    rd_chk(8'hE8, '1, 32'hC3, "R6");
    rd_chk(8'hE8, '1, 32'd0, "R6");
    rd_chk(8'hEC, '1, 32'd0, "R6");
    rd_chk(8'hD8, '1, 32'd0, "R6");

    // R5/R7: fill incoming queue past full
    for (int i = 0; i < 10; i++) give_rx(8'(8'h40 + i));
    rd_chk(8'hD8, '1, 32'(DEP), "R5");
    chk(!rx_ready, "R5", 32'(rx_ready), 32'd0);
    rd_chk(8'h84, 32'h4, 32'h4, "R7");
    for (int i = 0; i < DEP; i++) rd_chk(8'hE8, '1, 32'(8'h40 + i), "R6");
    wr(8'h84, 32'h4);
    rd_chk(8'h84, 32'h4, 32'h0, "R7");

    // R7: instruction low mark, clear only after leaving it
    rd_chk(8'h84, 32'h3, 32'h3, "R7");
    for (int i = 0; i < 5; i++) wr(8'hE0, 32'(16'hC000 + i));
    wr(8'h84, 32'h0);
    rd_chk(8'h84, 32'h1, 32'h1, "R7");
    wr(8'h84, 32'h1);
    rd_chk(8'h84, 32'h1, 32'h0, "R7");
    for (int i = 0; i < 5; i++) take_cmd(16'(16'hC000 + i), "R3");

    // R9/R7/R8: sync event, mask, w1c
    sync_valid = 1'b1; sync_id = 8'h5A;
    @(negedge clk);
    sync_valid = 1'b0;
    rd_chk(8'hC0, '1, 32'h5A, "R9");
    rd_chk(8'h84, 32'h8, 32'h8, "R7");
    chk(!irq, "R8", 32'(irq), 32'd0);
    wr(8'h80, 32'h8);
    chk(irq, "R8", 32'(irq), 32'd1);
    rd_chk(8'h88, '1, 32'h8, "R8");
    wr(8'h84, 32'h0);
    rd_chk(8'h84, 32'h8, 32'h8, "R7");
    wr(8'h84, 32'h8);
    chk(!irq, "R8", 32'(irq), 32'd0);
    rd_chk(8'h88, '1, 32'h0, "R8");
    rd_chk(8'h80, '1, 32'h8, "R8");

    // R10: unmapped and read-only
    rd_chk(8'h10, '1, 32'd0, "R10");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'hD0, 32'h0);
    rd_chk(8'h00, '1, exp_version(), "R10");
    rd_chk(8'hD0, '1, exp_room(0), "R10");

    // Random rounds on the instruction path (R3)
    for (int r = 0; r < 12; r++) begin
      int n = 1 + int'($urandom % 10);
      q.delete();
      for (int i = 0; i < n; i++) begin
        logic [15:0] d = 16'($urandom);
        wr(8'hE0, {16'($urandom), d});
        if (q.size() < DEP) q.push_back(d);
      end
      rd_chk(8'hD0, '1, exp_room(n), "R3");
      while (q.size() > 0) begin
        if ($urandom % 3 == 0) @(negedge clk);
        take_cmd(q.pop_front(), "R3");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule